// File: doc/BRIEF.md
# Flash Buffered-Programming Host Sequencer

This block is a bus master that takes a NOR-style flash through one buffered factory-programming session. Software or a DMA front end gives it a block start address, a word count and a per-loop poll limit, then pulses `start`. The data words to be written arrive on a valid/ready stream. The sequencer does the rest of the work. It sends the open and confirm commands and waits for the flash engine to accept data. It then loads the data in 32-word buffers and waits for each buffer to be programmed. At the end it closes the session, reads the final status and puts the device back in read-array mode.

The flash port is a simple request/acknowledge bus. A request stays up, with address, direction and write data held steady, until the flash returns a one-cycle acknowledge. On a read, the status byte arrives with that acknowledge.

The flash status byte is read differently in each phase. Bit 7 means "engine not ready" while the session opens, and "close finished" at the end. Bit 0 means "not ready for data" before a buffer, and "still programming" after one. Every poll loop stops after a set number of "not yet" answers. The sequencer reports one result code with a single-cycle `done`. The codes are: 0 none, 1 bad argument, 2 supply voltage fault, 3 block locked, 4 program failure, 5 poll timeout.

Top module: `flash_bufprog_seq`

## Requirements
- R1: A start whose address has any of its low 5 bits set, or whose word count is zero or not a multiple of 32, ends with `done` and code 1 on the next cycle. No flash transaction is issued.
- R2: A valid session first writes 0x0080 and then 0x00D0, both to the start address.
- R3: While the session opens, status reads at the start address repeat until bit 7 reads 0. If bit 7 reads 1 with bit 3 set, the session ends with code 2. If bit 7 reads 1 with only bit 1 set, it ends with code 3. Bit 3 wins when both bits are set.
- R4: Before each buffer, status is polled until bit 0 reads 0. Exactly 32 stream words are then written to the start address, in stream order. Status is then polled until bit 0 reads 0 before the next buffer.
- R5: After the last buffer, exactly one write of 0xFFFF is issued. Its address is the start address with address bit 10 inverted, which lies outside the 1024-word block. No other transaction uses an address other than the start address.
- R6: After the close write, status is polled until bit 7 reads 1. The final code is then 2 if bit 3 is set, else 3 if bit 1 is set, else 4 if bit 4 is set, else 0.
- R7: Every session that passed the R1 checks ends with a write of 0x00FF to the start address, and `done` follows its acknowledge.
- R8: A poll loop tolerates `poll_limit` consecutive not-ready answers. The next not-ready answer ends the session with code 5.
- R9: A flash request keeps `f_req`, `f_we`, `f_addr` and `f_wdata` steady until `f_ack`. `s_ready` is never high while a flash request is up.
- R10: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse, and `err_code` holds the result from `done` until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| start_addr | input | ADDR_W | First word address of the session |
| word_count | input | CNT_W | Number of words to program |
| poll_limit | input | TMO_W | Not-ready answers tolerated per poll loop |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DATA_W | Stream word |
| s_ready | output | 1 | Stream word accepted |
| f_req | output | 1 | Flash transaction request |
| f_we | output | 1 | 1 = write, 0 = status read |
| f_addr | output | ADDR_W | Flash word address |
| f_wdata | output | DATA_W | Flash write data |
| f_ack | input | 1 | Flash transaction acknowledge |
| f_rdata | input | DATA_W | Status data, valid with `f_ack` on reads |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished, one-cycle pulse |
| err_code | output | 3 | Result code, valid from `done` |

## Verification
The hardest conditions to reach are the fault answers, because they depend on what the flash returns at one exact phase of the session. The fault cases are: a locked or unpowered block while the session opens, a program failure seen only in the final status, and an engine that never becomes ready. The bench therefore contains a behavioural flash. It enforces the command order, the addresses and the data words. Per test, it can be told to answer the open-phase polls with the lock bit, the voltage bit, both bits, or a permanent busy. It can also put the program-failure bit into the final status. The timeout case is pinned exactly by counting the status reads the model served.

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int BUF_WORDS = 32,
  parameter int BLK_LOG2  = 10,
  parameter int TMO_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic [TMO_W-1:0]  poll_limit,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              f_req,
  output logic              f_we,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_wdata,
  input  logic              f_ack,
  input  logic [DATA_W-1:0] f_rdata,
  output logic              busy,
  output logic              done,
  output logic [2:0]        err_code
);
  localparam int BUF_LOG2 = $clog2(BUF_WORDS);
  localparam logic [ADDR_W-1:0] BLK_FLIP = ADDR_W'(1) << BLK_LOG2;
  localparam logic [2:0] ERR_NONE = 3'd0, ERR_ARG = 3'd1, ERR_VPP = 3'd2,
                         ERR_LOCK = 3'd3, ERR_PROG = 3'd4, ERR_TMO = 3'd5;

  typedef enum logic [3:0] {
    S_IDLE, S_OPEN, S_CONF, S_PSET, S_PRDY, S_LOAD, S_WDAT,
    S_PDONE, S_CLOSE, S_PEXIT, S_RDARR
  } st_t;

  st_t                st;
  logic [ADDR_W-1:0]  base;
  logic [CNT_W-1:0]   nbuf;
  logic [BUF_LOG2-1:0] wcnt;
  logic [TMO_W-1:0]   tmo, lim;
  logic [DATA_W-1:0]  wreg;

  wire bad_arg = (start_addr[BUF_LOG2-1:0] != '0) ||
                 (word_count[BUF_LOG2-1:0] != '0) || (word_count == '0);
  wire tmo_hit = (tmo == lim);

  assign busy    = (st != S_IDLE);
  assign s_ready = (st == S_LOAD);
  assign f_req   = !(st inside {S_IDLE, S_LOAD});
  assign f_we    = st inside {S_OPEN, S_CONF, S_WDAT, S_CLOSE, S_RDARR};
  assign f_addr  = (st == S_CLOSE) ? (base ^ BLK_FLIP) : base;

  always_comb begin
    case (st)
      S_OPEN:  f_wdata = DATA_W'(16'h0080);
      S_CONF:  f_wdata = DATA_W'(16'h00D0);
      S_WDAT:  f_wdata = wreg;
      S_CLOSE: f_wdata = '1;
      S_RDARR: f_wdata = DATA_W'(16'h00FF);
      default: f_wdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; err_code <= ERR_NONE;
      base <= '0; nbuf <= '0; wcnt <= '0; tmo <= '0; lim <= '0; wreg <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_arg) begin
            done <= 1'b1; err_code <= ERR_ARG;
          end else begin
            base <= start_addr; nbuf <= word_count >> BUF_LOG2;
            lim <= poll_limit; tmo <= '0; err_code <= ERR_NONE; st <= S_OPEN;
          end
        end
        S_OPEN:  if (f_ack) st <= S_CONF;
        S_CONF:  if (f_ack) st <= S_PSET;
        S_PSET: if (f_ack) begin
          if (!f_rdata[7]) begin tmo <= '0; st <= S_PRDY; end
          else if (f_rdata[3]) begin err_code <= ERR_VPP;  st <= S_RDARR; end
          else if (f_rdata[1]) begin err_code <= ERR_LOCK; st <= S_RDARR; end
          else if (tmo_hit) begin err_code <= ERR_TMO; st <= S_RDARR; end
          else tmo <= tmo + 1'b1;
        end
        S_PRDY: if (f_ack) begin
          if (!f_rdata[0]) begin tmo <= '0; wcnt <= '0; st <= S_LOAD; end
          else if (tmo_hit) begin err_code <= ERR_TMO; st <= S_RDARR; end
          else tmo <= tmo + 1'b1;
        end
        S_LOAD: if (s_valid) begin wreg <= s_data; st <= S_WDAT; end
        S_WDAT: if (f_ack) begin
          if (wcnt == BUF_LOG2'(BUF_WORDS - 1)) begin
            nbuf <= nbuf - 1'b1; st <= S_PDONE;
          end else begin
            wcnt <= wcnt + 1'b1; st <= S_LOAD;
          end
        end
        S_PDONE: if (f_ack) begin
          if (!f_rdata[0]) begin tmo <= '0; st <= (nbuf == '0) ? S_CLOSE : S_PRDY; end
          else if (tmo_hit) begin err_code <= ERR_TMO; st <= S_RDARR; end
          else tmo <= tmo + 1'b1;
        end
        S_CLOSE: if (f_ack) st <= S_PEXIT;
        S_PEXIT: if (f_ack) begin
          if (f_rdata[7]) begin
            tmo <= '0; st <= S_RDARR;
            err_code <= f_rdata[3] ? ERR_VPP : f_rdata[1] ? ERR_LOCK :
                        f_rdata[4] ? ERR_PROG : ERR_NONE;
          end
          else if (tmo_hit) begin err_code <= ERR_TMO; st <= S_RDARR; end
          else tmo <= tmo + 1'b1;
        end
        S_RDARR: if (f_ack) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && !f_ack) |=> (f_req && $stable(f_we) && $stable(f_addr) && $stable(f_wdata))); // R9
  AST_READY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !f_req); // R9
  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |-> (f_addr[BUF_LOG2-1:0] == '0)); // R1
  AST_OUTSIDE_IS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && (f_addr != base)) |-> (f_we && (f_wdata == '1))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && err_code <= ERR_TMO)); // R10
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err_code)); // R10
endmodule

// File: tb/test_flash_bufprog_seq.sv
module test_flash_bufprog_seq;
  localparam int AW = 24, DW = 16;
  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] start_addr = '0;
  logic [15:0] word_count = '0, poll_limit = 16'd50;
  logic s_valid, s_ready, f_req, f_we, f_ack, busy, done;
  logic [DW-1:0] s_data, f_wdata, f_rdata;
  logic [AW-1:0] f_addr;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  flash_bufprog_seq i_flash_bufprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_count(word_count), .poll_limit(poll_limit), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .f_req(f_req), .f_we(f_we),
    .f_addr(f_addr), .f_wdata(f_wdata), .f_ack(f_ack), .f_rdata(f_rdata),
    .busy(busy), .done(done), .err_code(err_code));

  int n_chk = 0, n_bad = 0;
  // stream source
  int idx = 0, total = 0; logic gappy = 0, tog = 0; logic [15:0] seed = 0;
  assign s_valid = (idx < total) && (!gappy || tog);
  assign s_data  = seed + 16'(idx);
  always @(posedge clk) begin
    tog <= ~tog;
    if (s_valid && s_ready) idx <= idx + 1;
  end

  // flash model
  int mode = 0, pc = 0, rw = 0, inbuf = 0, wcnt = 0;
  int txn = 0, nrd_open = 0, rdarr = 0, closes = 0, model_err = 0;
  logic [AW-1:0] mbase = '0;
  logic inj_lock = 0, inj_vpp = 0, inj_hang = 0, inj_prog = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      f_ack <= 0; f_rdata <= '0;
    end else begin
      f_ack <= 0;
      if (f_req && !f_ack) begin
        f_ack <= 1; txn++;
        if (f_we) begin
          case (mode)
            0: if (f_wdata == 16'h0080 && f_addr[4:0] == 0) begin mbase = f_addr; mode = 1; end
               else begin model_err++; $display("model: bad open cmd %h @%h", f_wdata, f_addr); end
            1: if (f_wdata == 16'h00D0 && f_addr == mbase) begin mode = 2; pc = 3; end
               else begin model_err++; $display("model: bad confirm %h", f_wdata); end
            3: if (f_addr == mbase) begin
                 if (f_wdata != seed + 16'(wcnt)) begin model_err++; $display("model: data %h exp %h", f_wdata, seed + 16'(wcnt)); end
                 wcnt++; inbuf++;
                 if (inbuf == 32) begin inbuf = 0; mode = 4; pc = 3; end
               end else if (f_wdata == 16'hFFFF && f_addr[AW-1:10] != mbase[AW-1:10] && inbuf == 0) begin
                 mode = 5; pc = 2; closes++;
               end else begin model_err++; $display("model: stray write @%h", f_addr); end
            default: if (f_wdata == 16'h00FF && f_addr == mbase) begin mode = 0; rdarr++; end
                     else begin model_err++; $display("model: unexpected write %h", f_wdata); end
          endcase
        end else begin
          if (f_addr != mbase) begin model_err++; $display("model: read @%h", f_addr); end
          case (mode)
            2: begin
                 nrd_open++;
                 if (inj_vpp || inj_lock) f_rdata <= 16'h0080 | (inj_vpp ? 16'h8 : 16'h0) | (inj_lock ? 16'h2 : 16'h0);
                 else if (inj_hang) f_rdata <= 16'h0080;
                 else if (pc > 0) begin pc--; f_rdata <= 16'h0080; end
                 else begin f_rdata <= 16'h0000; mode = 3; rw = 1; end
               end
            3: if (rw > 0) begin rw--; f_rdata <= 16'h0001; end else f_rdata <= 16'h0000;
            4: if (pc > 0) begin pc--; f_rdata <= 16'h0001; end
               else begin f_rdata <= 16'h0000; mode = 3; rw = 1; end
            5: if (pc > 0) begin pc--; f_rdata <= 16'h0000; end
               else f_rdata <= inj_prog ? 16'h0090 : 16'h0080;
            default: begin model_err++; f_rdata <= 16'h0000; $display("model: read in mode %0d", mode); end
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic prep(input logic [15:0] sd, input int tot, input logic gp);
    mode = 0; pc = 0; rw = 0; inbuf = 0; wcnt = 0; txn = 0; nrd_open = 0;
    rdarr = 0; closes = 0; model_err = 0;
    inj_lock = 0; inj_vpp = 0; inj_hang = 0; inj_prog = 0;
    seed = sd; idx = 0; total = tot; gappy = gp;
  endtask

  task automatic run(input logic [AW-1:0] a, input logic [15:0] cnt, input logic [15:0] lim, output int code);
    int n = 0;
    @(negedge clk); start_addr = a; word_count = cnt; poll_limit = lim; start = 1;
    @(negedge clk); start = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    code = int'(err_code);
  endtask

  task automatic t_reset();
    check(busy == 0, "R10 reset busy", int'(busy), 0);
    check(done == 0, "R10 reset done", int'(done), 0);
    check(f_req == 0, "R9 reset f_req", int'(f_req), 0);
    check(s_ready == 0, "R9 reset s_ready", int'(s_ready), 0);
  endtask

  task automatic t_two_buffers();
    int code, bsy;
    prep(16'h1200, 64, 0);
    @(negedge clk); start_addr = 24'h012340; word_count = 64; poll_limit = 50; start = 1;
    @(negedge clk); start = 0; bsy = int'(busy);
    while (!done) @(negedge clk);
    code = int'(err_code);
    check(bsy == 1, "R10 busy after start", bsy, 1);
    check(code == 0, "R6 clean code", code, 0);
    check(wcnt == 64, "R4 words programmed", wcnt, 64);
    check(idx == 64, "R4 stream consumed", idx, 64);
    check(model_err == 0, "R2 R4 order and data", model_err, 0);
    check(closes == 1, "R5 single close", closes, 1);
    check(rdarr == 1, "R7 read-array return", rdarr, 1);
    repeat (3) @(negedge clk);
    check(err_code == 0 && !busy, "R10 code held", int'(err_code), 0);
  endtask

  task automatic t_gappy();
    int code;
    prep(16'h3000, 96, 1);
    run(24'h040000, 96, 50, code);
    check(code == 0, "R4 gappy code", code, 0);
    check(wcnt == 96, "R4 gappy words", wcnt, 96);
    check(model_err == 0, "R4 gappy order", model_err, 0);
  endtask

  task automatic t_reject();
    int code;
    prep(16'h0, 0, 0);
    run(24'h000048, 32, 50, code);
    check(code == 1, "R1 unaligned addr", code, 1);
    check(txn == 0, "R1 no bus traffic", txn, 0);
    run(24'h000040, 40, 50, code);
    check(code == 1, "R1 bad count", code, 1);
    run(24'h000040, 0, 50, code);
    check(code == 1, "R1 zero count", code, 1);
    check(txn == 0, "R1 still no traffic", txn, 0);
  endtask

  task automatic t_lock();
    int code;
    prep(16'h5000, 32, 0); inj_lock = 1;
    run(24'h080000, 32, 50, code);
    check(code == 3, "R3 locked block", code, 3);
    check(idx == 0, "R3 no data taken", idx, 0);
    check(rdarr == 1, "R7 read-array after lock", rdarr, 1);
  endtask

  task automatic t_vpp();
    int code;
    prep(16'h5000, 32, 0); inj_vpp = 1; inj_lock = 1;
    run(24'h080000, 32, 50, code);
    check(code == 2, "R3 vpp priority", code, 2);
    check(model_err == 0, "R7 vpp exit clean", model_err, 0);
  endtask

  task automatic t_prog_err();
    int code;
    prep(16'h6100, 32, 0); inj_prog = 1;
    run(24'h0A0400, 32, 50, code);
    check(code == 4, "R6 program error", code, 4);
    check(wcnt == 32, "R6 data written", wcnt, 32);
    check(closes == 1 && rdarr == 1, "R7 close then read-array", rdarr, 1);
  endtask

  task automatic t_timeout();
    int code;
    prep(16'h7000, 32, 0); inj_hang = 1;
    run(24'h0C0000, 32, 5, code);
    check(code == 5, "R8 timeout code", code, 5);
    check(nrd_open == 6, "R8 poll reads", nrd_open, 6);
    check(rdarr == 1, "R7 read-array after timeout", rdarr, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_two_buffers();
    t_gappy();
    t_reject();
    t_lock();
    t_vpp();
    t_prog_err();
    t_timeout();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule